// File: doc/BRIEF.md
# Double-Buffered Serial Audio Transmitter

This block is one transmit channel of a serial audio port. A host writes parallel samples into a two-entry buffer. The channel shifts them out MSB first on a serial data line, with a word-select line and a bit clock. A system word is a left slot followed by a right slot. Each slot is `SLOT_W` bit-clock periods long and carries one `DATA_W`-bit sample, followed by zero padding. The bit clock comes in on one of two pins, chosen by a configuration bit. It is sampled in the host clock domain through a synchronizer, and only its falling edges are used. Serial data and word select change right after a detected falling edge.

The channel is controlled by a three-state machine. CONFIG is the state after reset. Configuration fields may only be written here, and the serial outputs are held low. The transition CONFIG→RUN happens when the enable bit is written to 1. In RUN, a buffer entry is loaded at the start of every slot. The transition RUN→DRAIN happens when the enable bit is written to 0. DRAIN keeps shifting until the final bit of the right slot has been sent. The transition DRAIN→CONFIG happens on the bit-clock falling edge that ends that bit, and the idle flag then rises.

The buffer can be refilled in two ways. In DMA mode a request line stays high while the channel runs and the buffer has room. In interrupt mode the interrupt line carries that same condition instead. Underflow and overflow are kept as sticky flags that the host clears by writing 1.

Top module: `sat_tx`

## Requirements
- R1: After reset the channel is in CONFIG: `idle`=1, `sd_out`=0, `ws_out`=0, `dma_req`=0, `irq`=0, `underflow`=0, `overflow`=0.
- R2: Writing `en_val`=1 with `en_we` in CONFIG moves to RUN (`idle`=0). The first falling bit-clock edge afterwards starts the left slot.
- R3: In RUN a system word is 2·`SLOT_W` bits, left slot then right slot. Each slot carries its sample MSB first, followed by `SLOT_W`−`DATA_W` zero bits. Samples are sent in the order they were written, and data changes after bit-clock falling edges.
- R4: `ws_out` is 0 for the left slot and 1 for the right slot. It switches during the last bit of the preceding slot, one bit before the MSB.
- R5: In DMA mode (`cfg_dma`=1), `dma_req` is high while in RUN with fewer than two entries buffered, and `irq` reflects only the flags. In interrupt mode `dma_req` stays 0 and `irq` also covers the buffer-has-room condition. `irq` is always gated by `cfg_irq_en`.
- R6: When a slot starts with an empty buffer, `underflow` is set and stays set. The slot then carries the last sent sample (`cfg_zero_fill`=0) or all zeros (`cfg_zero_fill`=1).
- R7: A data write while both entries are held, and no entry leaves in the same cycle, is discarded and sets `overflow`.
- R8: Writing `flag_clr` with `flag_clr_we` clears the flags selected by 1 bits: bit 0 is `underflow`, bit 1 is `overflow`.
- R9: Configuration writes (`cfg_we`) are accepted only in CONFIG. In RUN or DRAIN they have no effect.
- R10: Writing `en_val`=0 in RUN lets the current system word finish. `idle` stays 0 until the last right-slot bit is done, then `idle`=1 and `sd_out`=0.
- R11: `cfg_aclk`=0 takes the bit clock from `sck_in` and `cfg_aclk`=1 takes it from `aclk_in`. The unselected pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dma | input | 1 | Refill mode: 1 DMA, 0 interrupt |
| cfg_aclk | input | 1 | Bit clock source: 0 `sck_in`, 1 `aclk_in` |
| cfg_zero_fill | input | 1 | Underflow fill: 1 zeros, 0 repeat last |
| cfg_irq_en | input | 1 | Interrupt enable |
| en_we | input | 1 | Enable bit write strobe |
| en_val | input | 1 | Enable bit value |
| dat_we | input | 1 | Sample write strobe |
| dat_wdata | input | DATA_W | Sample value |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Clear mask: bit 0 underflow, bit 1 overflow |
| sck_in | input | 1 | Dedicated serial bit clock |
| aclk_in | input | 1 | Audio clock pin |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select |
| dma_req | output | 1 | DMA refill request |
| irq | output | 1 | Interrupt |
| idle | output | 1 | Channel in CONFIG |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The main serial path is tried with three input patterns. The first is a buffer that the DMA request keeps full, which exposes slot order, MSB-first bit order, padding and word-select placement. The second is a stopped feed, which shows whether the fill repeats the last sample or sends zeros, and whether that choice stayed locked against a write made while running. The third runs in interrupt mode from the other clock pin at a different rate, which shows whether the source select really routes the clock and keeps the DMA request silent. A disable issued part-way through the right slot shows whether the word is completed before idle rises, and an over-full preload shows that the surplus sample never appears on the line.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2
    } sat_state_e;
endpackage

// File: rtl/sat_bclk_sync.sv
module sat_bclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_b,
    input  logic clk_a,
    input  logic clk_b,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              raw;

    assign raw = sel_b ? clk_b : clk_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sat_buf2.sv
module sat_buf2 #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        cnt,
    output logic              ovf_evt
);
    logic [DATA_W-1:0] head_q, tail_q;
    logic [1:0]        cnt_q;
    logic              wr_ok;

    assign wr_ok   = wr && (cnt_q != 2'd2 || pop);
    assign ovf_evt = wr && !wr_ok;
    assign rdata   = head_q;
    assign cnt     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= 2'd0;
        end else if (pop && wr_ok) begin
            if (cnt_q == 2'd2) begin
                head_q <= tail_q;
                tail_q <= wdata;
            end else begin
                head_q <= wdata;
            end
        end else if (pop) begin
            head_q <= tail_q;
            cnt_q  <= cnt_q - 2'd1;
        end else if (wr_ok) begin
            if (cnt_q == 2'd0) head_q <= wdata;
            else               tail_q <= wdata;
            cnt_q <= cnt_q + 2'd1;
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 2'd2);
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cnt_q == 2'd2 && !pop) |=> (cnt_q == 2'd2 && $stable(tail_q)));
endmodule

// File: rtl/sat_shift_fsm.sv
module sat_shift_fsm
    import sat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              en_we,
    input  logic              en_val,
    input  logic [1:0]        buf_cnt,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              fill_zero,
    output logic              pop,
    output logic              uf_evt,
    output logic              sd,
    output logic              ws,
    output sat_state_e        state
);
    localparam int PW = $clog2(2 * SLOT_W);
    localparam logic [PW-1:0] LAST = PW'(2 * SLOT_W - 1);
    localparam logic [PW-1:0] MID  = PW'(SLOT_W - 1);
    localparam logic [PW-1:0] HALF = PW'(SLOT_W);

    sat_state_e        state_q, state_d;
    logic [PW-1:0]     pos_q, pos_nx, pos_ahead;
    logic [SLOT_W-1:0] sr_q, slot_word;
    logic [DATA_W-1:0] last_q;
    logic              ws_q;
    logic              at_end, slot_edge, stop, shift_en, load, have;

    assign at_end    = (pos_q == LAST);
    assign slot_edge = at_end || (pos_q == MID);
    assign stop      = (state_q == ST_DRAIN) && at_end;
    assign shift_en  = bit_fall && (state_q != ST_CONFIG) && !stop;
    assign load      = shift_en && slot_edge;
    assign have      = (buf_cnt != 2'd0);
    assign pop       = load && have;
    assign uf_evt    = load && !have;
    assign pos_nx    = at_end ? '0 : pos_q + 1'b1;
    assign pos_ahead = (pos_nx == LAST) ? '0 : pos_nx + 1'b1;

    always_comb begin
        slot_word = '0;
        slot_word[SLOT_W-1 -: DATA_W] = have ? buf_data : (fill_zero ? '0 : last_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG: if (en_we && en_val)    state_d = ST_RUN;
            ST_RUN:    if (en_we && !en_val)   state_d = ST_DRAIN;
            ST_DRAIN:  if (bit_fall && at_end) state_d = ST_CONFIG;
            default:                           state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= LAST;
            sr_q   <= '0;
            ws_q   <= 1'b0;
            last_q <= '0;
        end else if (state_q == ST_CONFIG || (bit_fall && stop)) begin
            pos_q <= LAST;
            sr_q  <= '0;
            ws_q  <= 1'b0;
        end else if (shift_en) begin
            pos_q <= pos_nx;
            ws_q  <= (pos_ahead >= HALF);
            sr_q  <= load ? slot_word : (sr_q << 1);
            if (pop) last_q <= buf_data;
        end
    end

    assign sd    = sr_q[SLOT_W-1];
    assign ws    = ws_q;
    assign state = state_q;

    p_cfg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIG) |-> (!sd && !ws));
    p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_fall |=> $stable(pos_q));
    p_ws_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CONFIG && !$stable(ws_q)) |-> (pos_q == MID || pos_q == LAST));
    p_drain_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && at_end) |-> !pop);
endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dma,
    input  logic              cfg_aclk,
    input  logic              cfg_zero_fill,
    input  logic              cfg_irq_en,
    input  logic              en_we,
    input  logic              en_val,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              flag_clr_we,
    input  logic [1:0]        flag_clr,
    input  logic              sck_in,
    input  logic              aclk_in,
    output logic              sd_out,
    output logic              ws_out,
    output logic              dma_req,
    output logic              irq,
    output logic              idle,
    output logic              underflow,
    output logic              overflow
);
    sat_state_e        state;
    logic [3:0]        cfg_q;
    logic              bit_fall, pop, uf_evt, ovf_evt;
    logic [1:0]        buf_cnt;
    logic [DATA_W-1:0] buf_data;
    logic              uf_q, ovf_q, need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cfg_q <= 4'b0;
        else if (cfg_we && state == ST_CONFIG)    cfg_q <= {cfg_irq_en, cfg_zero_fill, cfg_aclk, cfg_dma};
    end

    sat_bclk_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sel_b(cfg_q[1]),
        .clk_a(sck_in), .clk_b(aclk_in), .fall(bit_fall)
    );

    sat_buf2 #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(dat_we), .wdata(dat_wdata), .pop(pop),
        .rdata(buf_data), .cnt(buf_cnt), .ovf_evt(ovf_evt)
    );

    sat_shift_fsm #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .en_we(en_we), .en_val(en_val),
        .buf_cnt(buf_cnt), .buf_data(buf_data), .fill_zero(cfg_q[2]),
        .pop(pop), .uf_evt(uf_evt), .sd(sd_out), .ws(ws_out), .state(state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            uf_q  <= (uf_q  & ~(flag_clr_we & flag_clr[0])) | uf_evt;
            ovf_q <= (ovf_q & ~(flag_clr_we & flag_clr[1])) | ovf_evt;
        end
    end

    assign need      = (buf_cnt != 2'd2) && (state == ST_RUN);
    assign dma_req   = cfg_q[0] & need;
    assign irq       = cfg_q[3] & (uf_q | ovf_q | (~cfg_q[0] & need));
    assign idle      = (state == ST_CONFIG);
    assign underflow = uf_q;
    assign overflow  = ovf_q;

    p_cfg_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CONFIG) |=> $stable(cfg_q));
    p_uf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !(flag_clr_we && flag_clr[0])) |=> uf_q);
    p_dma_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !dma_req);
endmodule

// File: tb/sat_tx_tb.sv
module sat_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int SW = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_dma = 0, cfg_aclk = 0, cfg_zero_fill = 0, cfg_irq_en = 0;
    logic en_we = 0, en_val = 0, dat_we = 0, flag_clr_we = 0;
    logic [DW-1:0] dat_wdata = '0;
    logic [1:0] flag_clr = 2'b0;
    logic sck_in = 1'b0, aclk_in = 1'b0;
    logic sd_out, ws_out, dma_req, irq, idle, underflow, overflow;

    int checks = 0, fails = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_sent = '0;
    bit exp_dma = 1'b1, exp_zero = 1'b0, use_aclk = 1'b0, feed_on = 1'b0;
    int gen_idx = 0, man_req = 0, man_ack = 0;
    logic [DW-1:0] man_val = '0;
    logic bclk;

    assign bclk = use_aclk ? aclk_in : sck_in;

    sat_tx #(.DATA_W(DW), .SLOT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dma(cfg_dma), .cfg_aclk(cfg_aclk),
        .cfg_zero_fill(cfg_zero_fill), .cfg_irq_en(cfg_irq_en), .en_we(en_we), .en_val(en_val),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
        .sck_in(sck_in), .aclk_in(aclk_in), .sd_out(sd_out), .ws_out(ws_out),
        .dma_req(dma_req), .irq(irq), .idle(idle), .underflow(underflow), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin #2; forever #(8*CLK_PERIOD) sck_in = ~sck_in; end
    initial begin #3; forever #(6*CLK_PERIOD) aclk_in = ~aclk_in; end

    function automatic logic [DW-1:0] gen(int i);
        return DW'(32'h9E37_79B9 * 32'(i + 7));
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: the only process driving the data port; pushes expected samples
    always @(negedge clk) begin
        dat_we = 1'b0;
        if (man_ack != man_req) begin
            dat_we = 1'b1; dat_wdata = man_val; man_ack = man_req;
        end else if (feed_on && (exp_dma ? dma_req : irq)) begin
            dat_we = 1'b1; dat_wdata = gen(gen_idx);
            exp_q.push_back(gen(gen_idx));
            gen_idx++;
        end
    end

    task automatic man_write(logic [DW-1:0] v, bit accepted);
        man_val = v; man_req++;
        wait (man_ack == man_req);
        if (accepted) exp_q.push_back(v);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic cfg_write(bit dma, bit ak, bit zf, bit ie);
        @(negedge clk);
        cfg_we = 1; cfg_dma = dma; cfg_aclk = ak; cfg_zero_fill = zf; cfg_irq_en = ie;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic en_write(bit v);
        @(negedge clk); en_we = 1; en_val = v;
        @(negedge clk); en_we = 0;
    endtask

    task automatic clr_write(logic [1:0] m);
        @(negedge clk); flag_clr_we = 1; flag_clr = m;
        @(negedge clk); flag_clr_we = 0; @(negedge clk);
    endtask

    task automatic start_run();
        @(posedge bclk);
        en_write(1'b1);
        chk(idle == 1'b0, "R2 idle after enable", idle, 0);
        @(negedge bclk);
    endtask

    // monitor: pops expected samples and compares each completed slot
    task automatic run_frames(int n, int dis_at);
        for (int f = 0; f < n; f++) begin
            logic [SW-1:0] w = '0;
            for (int b = 0; b < 2*SW; b++) begin
                @(posedge bclk);
                repeat (4) @(negedge clk);
                chk(ws_out == (((b + 1) % (2*SW)) >= SW), "R4 ws position", ws_out, b);
                if (!exp_dma) chk(dma_req == 1'b0, "R5 no dma request in irq mode", dma_req, 0);
                if (dis_at >= 0 && f == n-1 && b > dis_at)
                    chk(idle == 1'b0, "R10 idle held during drain", idle, 0);
                w = {w[SW-2:0], sd_out};
                if ((b % SW) == SW-1) begin
                    logic [SW-1:0] es = '0;
                    logic [DW-1:0] v;
                    string tag;
                    if (exp_q.size() != 0) begin v = exp_q.pop_front(); tag = "R3 slot data"; end
                    else begin v = exp_zero ? '0 : last_sent; tag = "R6 underflow fill"; end
                    last_sent = v;
                    es[SW-1 -: DW] = v;
                    chk(w == es, tag, w, es);
                    w = '0;
                end
                if (dis_at >= 0 && f == n-1 && b == dis_at) en_write(1'b0);
            end
        end
        if (dis_at >= 0) begin
            @(negedge bclk);
            repeat (5) @(negedge clk);
            chk(idle == 1'b1, "R10 idle after word end", idle, 1);
            chk(sd_out == 1'b0, "R10 data low after drain", sd_out, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle == 1, "R1 idle", idle, 1);
        chk(sd_out == 0 && ws_out == 0, "R1 serial quiet", {sd_out, ws_out}, 0);
        chk(dma_req == 0 && irq == 0, "R1 no request", {dma_req, irq}, 0);
        chk(underflow == 0 && overflow == 0, "R1 flags clear", {underflow, overflow}, 0);

        // DMA mode, dedicated clock, repeat-last fill, interrupts on
        cfg_write(1, 0, 0, 1);
        chk(dma_req == 0, "R5 no request in config", dma_req, 0);
        man_write(16'h8001, 1);
        man_write(16'h7FFE, 1);
        man_write(16'hDEAD, 0);
        chk(overflow == 1, "R7 overflow set", overflow, 1);
        chk(irq == 1, "R5 irq from overflow", irq, 1);
        clr_write(2'b10);
        chk(overflow == 0, "R8 overflow cleared", overflow, 0);
        chk(irq == 0, "R5 irq released", irq, 0);

        start_run();
        feed_on = 1;
        run_frames(4, -1);
        chk(gen_idx > 0, "R5 dma requests served", gen_idx, 1);
        chk(underflow == 0, "R6 no underflow while fed", underflow, 0);
        cfg_write(1, 0, 1, 1);  // attempted change while running must be ignored (R9)
        feed_on = 0;
        @(negedge clk);
        run_frames(3, -1);
        chk(underflow == 1, "R6 underflow sticky", underflow, 1);
        chk(irq == 1, "R5 irq from underflow in dma mode", irq, 1);
        feed_on = 1;
        run_frames(2, 25);

        // interrupt mode, audio clock pin, zero fill
        clr_write(2'b01);
        chk(underflow == 0, "R8 underflow cleared", underflow, 0);
        cfg_write(0, 1, 1, 1);
        exp_dma = 0; exp_zero = 1; use_aclk = 1;
        chk(irq == 0, "R5 no irq in config", irq, 0);
        start_run();
        run_frames(3, -1);
        feed_on = 0;
        @(negedge clk);
        run_frames(3, 30);
        chk(underflow == 1, "R6 zero-fill underflow", underflow, 1);
        chk(dma_req == 0, "R11 aclk run dma quiet", dma_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule